// File: doc/BRIEF.md
# Addressed Peripheral Interface Unit

This unit joins one peripheral to a processor I/O bus that many such units share. On each clock edge where the bus strobe is high, the unit compares the device address on the bus with its own fixed address, set by a parameter. When the two match, it decodes a two-bit function code and carries out the command. A control command loads a control register that drives the peripheral. A status command returns the flag word. A data output command loads an output register bound for the peripheral. A data input command returns the word the peripheral left in the input buffer.

The read data output is zero except during a matching status or data input command, so the outputs of several units can be ORed onto one bus. The peripheral side has two valid/ready streams. The output stream presents the output register. It holds valid and data steady until ready is seen high on a clock edge. A new data output command replaces a word that is still pending. The input stream raises ready only while the input buffer is empty. A word is captured on the edge where valid and ready are both high. Back-pressure on input therefore lasts until the processor reads the buffer.

Top module: `addr_io_port`

## Requirements
- R1: After reset, dev_ctrl is zero, out_valid is low, in_ready is high and bus_rdata is zero.
- R2: A strobed command whose bus_addr differs from DEV_ADDR changes no register and leaves bus_rdata at zero.
- R3: bus_rdata is zero whenever the strobe is low, the address does not match, or bus_func is 00 (control) or 10 (data output).
- R4: A matching command with bus_func 00 loads bus_wdata[CTRL_W-1:0] into dev_ctrl, visible from the next cycle.
- R5: In the same cycle, a matching command with bus_func 01 drives the status word on bus_rdata. Bit 0 is the input-ready flag (input buffer full). Bit 1 is the output-empty flag (no word pending). Bits 2 and up hold dev_stat, and all higher bits are zero.
- R6: A matching command with bus_func 10 loads bus_wdata into the output register. From the next cycle, out_valid is high, out_data carries the word and status bit 1 is clear.
- R7: While out_valid is high and out_ready is low, out_valid and out_data hold. After an edge with out_ready high, out_valid is low and status bit 1 is set.
- R8: The unit captures in_data on an edge where in_valid and in_ready are both high. From the next cycle, in_ready is low and status bit 0 is set. In that state, further in_valid pulses leave the buffer unchanged.
- R9: In the same cycle, a matching command with bus_func 11 drives the input buffer on bus_rdata. From the next cycle, in_ready is high again and status bit 0 is clear.
- R10: A data output command issued while a word is still pending replaces it. out_valid stays high and out_data shows the newer word.
- R11: When a peripheral deposit and a data input command share an edge with the buffer empty, the deposit wins. The buffer ends full and holds the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Command strobe |
| bus_addr | input | ADDR_W | Device address on the shared bus |
| bus_func | input | 2 | Function code: 00 control, 01 status, 10 data out, 11 data in |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_rdata | output | DATA_W | Read data, zero unless a matching read command |
| dev_ctrl | output | CTRL_W | Control register driving the peripheral |
| dev_stat | input | STAT_W | Peripheral status conditions |
| out_valid | output | 1 | Output word pending |
| out_ready | input | 1 | Peripheral takes the output word |
| out_data | output | DATA_W | Output word |
| in_valid | input | 1 | Peripheral offers an input word |
| in_ready | output | 1 | Input buffer empty |
| in_data | input | DATA_W | Input word from the peripheral |

## Verification
On every cycle, the assertions check the following. The read bus stays quiet outside matching read commands. A foreign address leaves the control register alone. A control write lands on dev_ctrl. A pending output word holds under back-pressure. A captured input word blocks further deposits, and a matching data input read releases the buffer. Only the scenarios can show the exact status word layout and the data value returned by a data input read. The same holds for overwriting a pending output word and for the deposit-wins rule when a read meets a deposit.

// File: rtl/aip_pkg.sv
package aip_pkg;

  typedef enum logic [1:0] {
    FN_CTRL = 2'b00,
    FN_STAT = 2'b01,
    FN_DOUT = 2'b10,
    FN_DIN  = 2'b11
  } fn_e;

  typedef struct packed {
    logic ctrl_we;
    logic stat_rd;
    logic dout_we;
    logic din_rd;
  } cmd_t;

endpackage

// File: rtl/aip_cmd_decode.sv
module aip_cmd_decode
  import aip_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        func,
  output cmd_t              cmd
);

  logic hit;
  fn_e  fn;

  assign hit = stb && (addr == DEV_ADDR);
  assign fn  = fn_e'(func);

  always_comb begin
    cmd = '0;
    if (hit) begin
      unique case (fn)
        FN_CTRL: cmd.ctrl_we = 1'b1;
        FN_STAT: cmd.stat_rd = 1'b1;
        FN_DOUT: cmd.dout_we = 1'b1;
        FN_DIN:  cmd.din_rd  = 1'b1;
        default: cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/aip_out_slot.sv
module aip_out_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              valid,
  input  logic              ready,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/aip_in_slot.sv
module aip_in_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  output logic              ready,
  input  logic [DATA_W-1:0] data,
  input  logic              drain,
  output logic              full,
  output logic [DATA_W-1:0] held
);

  logic take;

  assign ready = !full;
  assign take  = valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (take) begin
      full <= 1'b1;
      held <= data;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/aip_read_mux.sv
module aip_read_mux
  import aip_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 6
) (
  input  cmd_t              cmd,
  input  logic              in_full,
  input  logic              out_empty,
  input  logic [STAT_W-1:0] dev_stat,
  input  logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] rdata
);

  localparam int USED_W = STAT_W + 2;

  logic [DATA_W-1:0] stat_word;

  generate
    if (DATA_W > USED_W) begin : g_pad
      assign stat_word = {{(DATA_W-USED_W){1'b0}}, dev_stat, out_empty, in_full};
    end else begin : g_exact
      assign stat_word = {dev_stat, out_empty, in_full};
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (cmd.stat_rd) rdata = stat_word;
    if (cmd.din_rd)  rdata = in_word;
  end

endmodule

// File: rtl/addr_io_port.sv
module addr_io_port
  import aip_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter int STAT_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_func,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CTRL_W-1:0] dev_ctrl,
  input  logic [STAT_W-1:0] dev_stat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data
);

  cmd_t              cmd;
  logic              in_full;
  logic [DATA_W-1:0] in_word;

  aip_cmd_decode #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_dec (
    .stb (bus_stb),
    .addr(bus_addr),
    .func(bus_func),
    .cmd (cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           dev_ctrl <= '0;
    else if (cmd.ctrl_we) dev_ctrl <= bus_wdata[CTRL_W-1:0];
  end

  aip_out_slot #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd.dout_we),
    .load_data(bus_wdata),
    .valid    (out_valid),
    .ready    (out_ready),
    .data     (out_data)
  );

  aip_in_slot #(.DATA_W(DATA_W)) u_in (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(in_valid),
    .ready(in_ready),
    .data (in_data),
    .drain(cmd.din_rd),
    .full (in_full),
    .held (in_word)
  );

  aip_read_mux #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_rmux (
    .cmd      (cmd),
    .in_full  (in_full),
    .out_empty(!out_valid),
    .dev_stat (dev_stat),
    .in_word  (in_word),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/aip_checker.sv
module aip_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_stb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_func,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CTRL_W-1:0] dev_ctrl,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              in_valid,
  input logic              in_ready
);

  logic hit;
  assign hit = bus_stb && (bus_addr == DEV_ADDR);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (dev_ctrl == '0) && !out_valid && in_ready);

  p_foreign_keeps_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_addr != DEV_ADDR) |=> $stable(dev_ctrl));

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && bus_func[0]) |-> (bus_rdata == '0));

  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_func == 2'b00) |=> (dev_ctrl == $past(bus_wdata[CTRL_W-1:0])));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(hit && bus_func == 2'b10))
      |=> (out_valid && $stable(out_data)));

  p_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_in_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_func == 2'b11 && !in_ready) |=> in_ready);

endmodule

bind addr_io_port aip_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_addr(bus_addr),
  .bus_func(bus_func), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dev_ctrl(dev_ctrl), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/tb_addr_io_port.sv
module tb_addr_io_port;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 8;
  localparam int STAT_W = 6;
  localparam logic [ADDR_W-1:0] DEV = 8'h5A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_stb = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_func = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [CTRL_W-1:0] dev_ctrl;
  logic [STAT_W-1:0] dev_stat = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  addr_io_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
                 .STAT_W(STAT_W), .DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_addr(bus_addr),
    .bus_func(bus_func), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_ctrl(dev_ctrl), .dev_stat(dev_stat), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [ADDR_W-1:0] a, logic [1:0] f, logic [DATA_W-1:0] w);
    @(negedge clk);
    bus_stb = 1'b1; bus_addr = a; bus_func = f; bus_wdata = w;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_stb = 1'b0; bus_addr = '0; bus_func = '0; bus_wdata = '0;
    #1;
  endtask

  task automatic read_status(output logic [DATA_W-1:0] v);
    drive(DEV, 2'b01, '0);
    v = bus_rdata;
    idle();
  endtask

  task automatic t_reset();
    check("R1 ctrl", 32'(dev_ctrl), 0);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 rdata", 32'(bus_rdata), 0);
  endtask

  task automatic t_control();
    drive(DEV, 2'b00, 16'h12A5);
    check("R3 rdata on control", 32'(bus_rdata), 0);
    idle();
    check("R4 ctrl loaded", 32'(dev_ctrl), 32'hA5);
    drive(DEV, 2'b00, 16'h003C);
    idle();
    check("R4 ctrl reloaded", 32'(dev_ctrl), 32'h3C);
  endtask

  task automatic t_foreign();
    drive(DEV ^ 8'h01, 2'b00, 16'h00FF);
    check("R2 rdata foreign ctrl", 32'(bus_rdata), 0);
    drive(DEV ^ 8'h80, 2'b10, 16'hDEAD);
    drive(DEV ^ 8'h01, 2'b01, 16'h0);
    check("R2 rdata foreign status", 32'(bus_rdata), 0);
    idle();
    check("R2 ctrl unchanged", 32'(dev_ctrl), 32'h3C);
    check("R2 out_valid unchanged", 32'(out_valid), 0);
    @(negedge clk);
    bus_func = 2'b01; bus_addr = DEV; #1;
    check("R3 rdata without strobe", 32'(bus_rdata), 0);
    idle();
  endtask

  task automatic t_status();
    logic [DATA_W-1:0] v;
    dev_stat = 6'h2B;
    read_status(v);
    check("R5 status word", 32'(v), 32'((6'h2B << 2) | 2'b10));
  endtask

  task automatic t_output();
    logic [DATA_W-1:0] v;
    out_ready = 1'b0;
    drive(DEV, 2'b10, 16'h1234);
    check("R3 rdata on data out", 32'(bus_rdata), 0);
    idle();
    check("R6 out_valid", 32'(out_valid), 1);
    check("R6 out_data", 32'(out_data), 32'h1234);
    read_status(v);
    check("R6 output-empty clear", 32'(v[1]), 0);
    repeat (3) idle();
    check("R7 held valid", 32'(out_valid), 1);
    check("R7 held data", 32'(out_data), 32'h1234);
    drive(DEV, 2'b10, 16'h5678);
    idle();
    check("R10 replaced word", 32'(out_data), 32'h5678);
    check("R10 still valid", 32'(out_valid), 1);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0; #1;
    check("R7 taken", 32'(out_valid), 0);
    read_status(v);
    check("R7 output-empty set", 32'(v[1]), 1);
  endtask

  task automatic t_input();
    logic [DATA_W-1:0] v;
    check("R8 ready when empty", 32'(in_ready), 1);
    @(negedge clk); in_valid = 1'b1; in_data = 16'hBEEF;
    @(negedge clk); in_valid = 1'b0; in_data = '0; #1;
    check("R8 ready dropped", 32'(in_ready), 0);
    read_status(v);
    check("R8 input-ready set", 32'(v[0]), 1);
    @(negedge clk); in_valid = 1'b1; in_data = 16'h1111;
    @(negedge clk); in_valid = 1'b0; in_data = '0;
    drive(DEV, 2'b11, '0);
    check("R9 read returns first word", 32'(bus_rdata), 32'hBEEF);
    idle();
    check("R9 ready restored", 32'(in_ready), 1);
    read_status(v);
    check("R9 input-ready clear", 32'(v[0]), 0);
  endtask

  task automatic t_collide();
    drive(DEV, 2'b11, '0);
    in_valid = 1'b1; in_data = 16'h7777;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    bus_stb = 1'b0; bus_func = '0; bus_addr = '0; #1;
    check("R11 deposit wins", 32'(in_ready), 0);
    drive(DEV, 2'b11, '0);
    check("R11 new word kept", 32'(bus_rdata), 32'h7777);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_control();
    t_foreign();
    t_status();
    t_output();
    t_input();
    t_collide();
    repeat (2) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule